// File: doc/BRIEF.md
# Receive Ring Write-Address and Room Tracker

This block follows the write position of a receive engine inside a ring of memory made of whole 256-byte pages. The ring is bounded by two page numbers: a first page, whose address is the page number with a zero low byte, and a stop page, which is the first page outside the ring. The ring therefore covers every address from first_page*256 up to stop_page*256-1. Each byte the engine stores advances the write address by one. When the address would step onto the stop page boundary, it returns to the start of the first page instead, and a wrap pulse is raised.

Alongside the address, the block holds a 16-bit room counter that the receive logic uses as scratch space for the bytes still allowed in the current frame. A start-of-frame strobe loads the counter from an initial value, and each stored byte decrements it by one. When the counter is zero the block reports exhaustion and refuses further bytes. The counter can be read as two 8-bit halves. The host may overwrite either half, but only while no reception is in progress, because a write during reception would upset the transfer.

Bytes arrive on a valid/ready handshake that carries no data: a byte is taken on a cycle with `wr_valid` and `wr_ready` both high. `wr_ready` is low while the room counter is zero and during the start-of-frame cycle. A source facing low `wr_ready` must hold `wr_valid` and retry later. A stalled offer changes nothing in the block.

Top module: `rxbuf_ring_tracker`

## Requirements
- R1: Synchronous reset (`rst_n` low at a clock edge) sets `cur_addr` to first_page*256, `room` to 0, `wrap` to 0, and `exhausted` to 1. While `sof` is low after reset, `wr_ready` is 0.
- R2: A cycle with `sof` high loads `room` with `init_room` at that clock edge, and `wr_ready` is 0 during that cycle.
- R3: A byte is taken on a cycle with `wr_valid` and `wr_ready` both high. After that edge, `room` has dropped by one, and `cur_addr` has risen by one unless R4 applies.
- R4: If the address after a taken byte would equal stop_page*256, `cur_addr` becomes first_page*256 instead. `wrap` is high for exactly the one cycle that follows that edge and is low at all other times.
- R5: A stop page of 0 places the ring's end at the top of the 16-bit space, so the wrap happens after address 0xFFFF.
- R6: `exhausted` is high exactly when `room` is 0. `wr_ready` equals `!exhausted && !sof`. An offer that is not taken leaves `cur_addr` and `room` unchanged and does not raise `wrap`.
- R7: `room_hi` always shows `room[15:8]`, and `room_lo` always shows `room[7:0]`.
- R8: With `rx_active` low, `host_wr_hi` replaces `room[15:8]` with `host_wdata`, and `host_wr_lo` replaces `room[7:0]` with `host_wdata`. A half that is not written keeps its value.
- R9: Host writes made while `rx_active` is high have no effect on `room`.
- R10: Within one cycle, `sof` takes priority over a taken byte, and a taken byte takes priority over a host write. A host write that loses is dropped.
- R11: A cycle with `wr_valid` low and no `sof` or host write changes neither `cur_addr` nor `room`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| first_page | input | 8 | Page number of the ring's first address |
| stop_page | input | 8 | First page past the ring (exclusive) |
| sof | input | 1 | Start-of-frame strobe; loads the room counter |
| init_room | input | 16 | Value loaded into the room counter at `sof` |
| wr_valid | input | 1 | Source offers one byte write |
| wr_ready | output | 1 | Block accepts the byte this cycle |
| rx_active | input | 1 | Reception in progress; blocks host writes |
| host_wr_hi | input | 1 | Host write strobe for the counter's upper byte |
| host_wr_lo | input | 1 | Host write strobe for the counter's lower byte |
| host_wdata | input | 8 | Host write data |
| cur_addr | output | 16 | Current write address in the ring |
| wrap | output | 1 | One-cycle pulse after the address wrapped |
| room | output | 16 | Room-remaining counter |
| room_hi | output | 8 | Upper byte of the room counter |
| room_lo | output | 8 | Lower byte of the room counter |
| exhausted | output | 1 | Room counter is zero |

## Verification
The bench walks every address of several rings: one-page and two-page rings, a ring at the bottom of the space, and a ring whose stop page is 0. Each walk continues past the wrap point, so a design that compares against the last address instead of the first excluded address would wrap one byte early or one byte late, and a design that does not handle a stop page of 0 would never return to the first page. Each walk's room budget is set slightly below the walk length. This exposes a counter that wraps from 0 to 0xFFFF, and a design that moves the address while stalled. Host writes are tried to each half separately, during reception, and in the same cycle as `sof` or a taken byte. A wrong priority or an ungated write then shows up as an unexpected counter value, and a borrow from 0x0100 down to 0x00FF checks that the two halves stay joined.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  localparam int unsigned PAGE_W_DEF = 8;
  localparam int unsigned OFS_W_DEF  = 8;
  localparam int unsigned LANE_W_DEF = 8;

  typedef enum logic [1:0] {
    ROOM_HOLD = 2'd0,
    ROOM_LOAD = 2'd1,
    ROOM_DEC  = 2'd2,
    ROOM_HOST = 2'd3
  } room_op_e;
endpackage

// File: rtl/rxbuf_addr_ring.sv
module rxbuf_addr_ring #(
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned OFS_W  = 8,
  localparam int unsigned ADDR_W = PAGE_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] first_page,
  input  logic [PAGE_W-1:0] stop_page,
  input  logic              step,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              wrap
);
  logic [ADDR_W-1:0] base_addr;
  logic [ADDR_W-1:0] limit_addr;
  logic [ADDR_W-1:0] next_addr;
  logic              hit_limit;

  assign base_addr  = {first_page, {OFS_W{1'b0}}};
  assign limit_addr = {stop_page, {OFS_W{1'b0}}};
  // a stop page of zero overflows next_addr to zero and matches naturally
  assign next_addr  = cur_addr + 1'b1;
  assign hit_limit  = (next_addr == limit_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= base_addr;
      wrap     <= 1'b0;
    end else begin
      wrap <= step && hit_limit;
      if (step) begin
        cur_addr <= hit_limit ? base_addr : next_addr;
      end
    end
  end

  // R3: a step moves the address by one unless it wrapped
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (wrap || cur_addr == $past(cur_addr) + 1'b1));

  // R4: after a wrap the address sits on a page boundary
  a_r4_wrap_on_page: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> (cur_addr[OFS_W-1:0] == '0));

  // R11: no step, no movement
  a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(cur_addr) && !wrap));
endmodule

// File: rtl/rxbuf_room_count.sv
module rxbuf_room_count
  import rxbuf_pkg::*;
#(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 2,
  localparam int unsigned CNT_W = LANE_W * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  room_op_e         op,
  input  logic [CNT_W-1:0] load_val,
  input  logic [LANES-1:0] lane_we,
  input  logic [LANE_W-1:0] lane_data,
  output logic [CNT_W-1:0] room,
  output logic             empty
);
  logic [CNT_W-1:0] host_next;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign host_next[g*LANE_W +: LANE_W] =
      lane_we[g] ? lane_data : room[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      room <= '0;
    end else begin
      unique case (op)
        ROOM_LOAD: room <= load_val;
        ROOM_DEC:  room <= room - 1'b1;
        ROOM_HOST: room <= host_next;
        default:   room <= room;
      endcase
    end
  end

  assign empty = (room == '0);

  // R2: a load captures the presented value
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    (op == ROOM_LOAD) |=> (room == $past(load_val)));

  // R3: a decrement removes exactly one
  a_r3_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (op == ROOM_DEC) |=> (room == $past(room) - 1'b1));

  // R6: an empty counter never rolls under
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && op != ROOM_LOAD && op != ROOM_HOST) |=> empty);

  // R11: hold keeps the value
  a_r11_room_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op == ROOM_HOLD) |=> $stable(room));
endmodule

// File: rtl/rxbuf_room_arb.sv
module rxbuf_room_arb
  import rxbuf_pkg::*;
#(
  parameter int unsigned LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  input  logic             wr_valid,
  input  logic             empty,
  input  logic             rx_active,
  input  logic [LANES-1:0] host_we,
  output logic             wr_ready,
  output logic             take,
  output room_op_e         op
);
  logic host_ok;

  assign wr_ready = !empty && !sof;
  assign take     = wr_valid && wr_ready;
  assign host_ok  = !rx_active && (|host_we);

  always_comb begin
    if (sof)          op = ROOM_LOAD;
    else if (take)    op = ROOM_DEC;
    else if (host_ok) op = ROOM_HOST;
    else              op = ROOM_HOLD;
  end

  // R9: host access never selected during reception
  a_r9_host_gated: assert property (@(posedge clk) disable iff (!rst_n)
    rx_active |-> (op != ROOM_HOST));

  // R6: nothing is taken from an empty counter
  a_r6_no_take_empty: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !take);
endmodule

// File: rtl/rxbuf_ring_tracker.sv
module rxbuf_ring_tracker
  import rxbuf_pkg::*;
#(
  parameter int unsigned PAGE_W = PAGE_W_DEF,
  parameter int unsigned OFS_W  = OFS_W_DEF,
  parameter int unsigned LANE_W = LANE_W_DEF,
  localparam int unsigned ADDR_W = PAGE_W + OFS_W,
  localparam int unsigned LANES  = 2,
  localparam int unsigned CNT_W  = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] first_page,
  input  logic [PAGE_W-1:0] stop_page,
  input  logic              sof,
  input  logic [CNT_W-1:0]  init_room,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              rx_active,
  input  logic              host_wr_hi,
  input  logic              host_wr_lo,
  input  logic [LANE_W-1:0] host_wdata,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              wrap,
  output logic [CNT_W-1:0]  room,
  output logic [LANE_W-1:0] room_hi,
  output logic [LANE_W-1:0] room_lo,
  output logic              exhausted
);
  logic             take;
  logic             empty;
  room_op_e         op;
  logic [LANES-1:0] host_we;

  assign host_we = {host_wr_hi, host_wr_lo};

  rxbuf_room_arb #(.LANES(LANES)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .sof       (sof),
    .wr_valid  (wr_valid),
    .empty     (empty),
    .rx_active (rx_active),
    .host_we   (host_we),
    .wr_ready  (wr_ready),
    .take      (take),
    .op        (op)
  );

  rxbuf_room_count #(.LANE_W(LANE_W), .LANES(LANES)) u_room (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .load_val  (init_room),
    .lane_we   (host_we),
    .lane_data (host_wdata),
    .room      (room),
    .empty     (empty)
  );

  rxbuf_addr_ring #(.PAGE_W(PAGE_W), .OFS_W(OFS_W)) u_ring (
    .clk        (clk),
    .rst_n      (rst_n),
    .first_page (first_page),
    .stop_page  (stop_page),
    .step       (take),
    .cur_addr   (cur_addr),
    .wrap       (wrap)
  );

  assign room_hi   = room[CNT_W-1 -: LANE_W];
  assign room_lo   = room[LANE_W-1:0];
  assign exhausted = empty;

  // R6: a stalled or frame-start cycle never moves the address
  a_r6_stall_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (exhausted || sof) |=> ($stable(cur_addr) && !wrap));

  // R4: a wrap lands on the first page
  a_r4_wrap_base: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> (cur_addr == {$past(first_page), {OFS_W{1'b0}}}));

  // R9: host strobes during reception leave the counter alone
  a_r9_host_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_active && !sof && !(wr_valid && wr_ready)) |=> $stable(room));
endmodule

// File: tb/rxbuf_ring_tracker_bench.sv
module rxbuf_ring_tracker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  first_page = '0;
  logic [7:0]  stop_page = 8'h01;
  logic        sof = 1'b0;
  logic [15:0] init_room = '0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic        rx_active = 1'b0;
  logic        host_wr_hi = 1'b0;
  logic        host_wr_lo = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [15:0] cur_addr;
  logic        wrap;
  logic [15:0] room;
  logic [7:0]  room_hi;
  logic [7:0]  room_lo;
  logic        exhausted;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [7:0]  m_beg, m_end;
  logic [15:0] m_addr, m_room;
  logic        m_wrap;

  always #2.5 clk = ~clk;

  rxbuf_ring_tracker u_rxbuf_ring_tracker (
    .clk(clk), .rst_n(rst_n), .first_page(first_page), .stop_page(stop_page),
    .sof(sof), .init_room(init_room), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rx_active(rx_active), .host_wr_hi(host_wr_hi), .host_wr_lo(host_wr_lo),
    .host_wdata(host_wdata), .cur_addr(cur_addr), .wrap(wrap), .room(room),
    .room_hi(room_hi), .room_lo(room_lo), .exhausted(exhausted)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_outs(input string addr_tag);
    chk(cur_addr === m_addr, addr_tag, cur_addr, m_addr);
    chk(room === m_room, "R3 room", room, m_room);
    chk(room_hi === m_room[15:8] && room_lo === m_room[7:0], "R7 halves",
        {room_hi, room_lo}, m_room);
    chk(exhausted === (m_room == 0), "R6 exhausted", exhausted, m_room == 0);
    chk(wrap === m_wrap, "R4 wrap", wrap, m_wrap);
  endtask

  // called at a negedge; returns at the next negedge with outputs checked
  task automatic cyc(input logic v, input logic s, input logic hh, input logic hl,
                     input logic act, input logic [7:0] hd, input logic [15:0] ld,
                     input string tag);
    logic tk;
    logic [15:0] nx;
    wr_valid = v; sof = s; host_wr_hi = hh; host_wr_lo = hl;
    rx_active = act; host_wdata = hd; init_room = ld;
    #1;
    chk(wr_ready === ((m_room != 0) && !s), "R6 ready", wr_ready,
        (m_room != 0) && !s);
    tk = v && (m_room != 0) && !s;
    if (s) m_room = ld;
    else if (tk) m_room = m_room - 1'b1;
    else if (!act) begin
      if (hh) m_room[15:8] = hd;
      if (hl) m_room[7:0] = hd;
    end
    m_wrap = 1'b0;
    if (tk) begin
      nx = m_addr + 1'b1;
      if (nx == {m_end, 8'h00}) begin
        m_addr = {m_beg, 8'h00};
        m_wrap = 1'b1;
      end else begin
        m_addr = nx;
      end
    end
    @(negedge clk);
    check_outs(tag);
  endtask

  task automatic do_reset(input logic [7:0] b, input logic [7:0] e);
    m_beg = b; m_end = e;
    first_page = b; stop_page = e;
    wr_valid = 0; sof = 0; host_wr_hi = 0; host_wr_lo = 0; rx_active = 0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_addr = {b, 8'h00}; m_room = '0; m_wrap = 1'b0;
    #1;
    chk(cur_addr === m_addr, "R1 addr", cur_addr, m_addr);
    chk(room === 16'h0, "R1 room", room, 0);
    chk(exhausted === 1'b1, "R1 exhausted", exhausted, 1);
    chk(wrap === 1'b0, "R1 wrap", wrap, 0);
    chk(wr_ready === 1'b0, "R1 ready", wr_ready, 0);
  endtask

  // walk the full ring and a few bytes past, with room a little short
  task automatic sweep(input logic [7:0] b, input int pages, input string tag);
    int span;
    span = pages * 256;
    do_reset(b, b + pages[7:0]);
    cyc(0, 1, 0, 0, 1, 8'h00, span[15:0] + 16'd2, "R2 load");
    for (int i = 0; i < span + 5; i++) cyc(1, 0, 0, 0, 1, 8'h00, 16'h0, tag);
    cyc(0, 0, 0, 0, 1, 8'h00, 16'h0, "R11 idle");
  endtask

  initial begin
    @(negedge clk);
    sweep(8'h00, 1, "R4 one page");
    sweep(8'h10, 2, "R3 two pages");
    sweep(8'h7E, 1, "R4 mid space");
    sweep(8'hFF, 1, "R5 stop page zero");
    sweep(8'hFE, 2, "R5 two pages to top");

    // host access and priority on a small ring
    do_reset(8'h20, 8'h21);
    cyc(0, 0, 1, 0, 0, 8'h01, 16'h0, "R8 host hi");
    cyc(0, 0, 0, 1, 0, 8'h00, 16'h0, "R8 host lo");
    cyc(1, 0, 0, 0, 1, 8'h00, 16'h0, "R3 borrow");
    cyc(0, 0, 1, 1, 1, 8'hAA, 16'h0, "R9 ignored");
    cyc(0, 0, 0, 0, 0, 8'h00, 16'h0, "R9 observe");
    cyc(1, 0, 1, 0, 0, 8'h55, 16'h0, "R10 byte over host");
    cyc(0, 1, 1, 1, 0, 8'h66, 16'h0123, "R10 sof over host");
    cyc(1, 1, 0, 0, 0, 8'h00, 16'h0002, "R2 no take on sof");
    cyc(0, 0, 0, 0, 0, 8'h00, 16'h0, "R11 valid low");
    cyc(1, 0, 0, 0, 1, 8'h00, 16'h0, "R3 take");
    cyc(1, 0, 0, 0, 1, 8'h00, 16'h0, "R3 take last");
    cyc(1, 0, 0, 0, 1, 8'h00, 16'h0, "R6 stalled");
    cyc(0, 0, 0, 1, 0, 8'h03, 16'h0, "R8 refill lo");
    cyc(1, 0, 0, 0, 0, 8'h00, 16'h0, "R6 resume");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule